// File: doc/BRIEF.md
# DAC Conversion Trigger and Data-Hold Controller

This block is the digital front end of a 12-bit digital-to-analog converter. Software programs it through a plain register port (write strobe, word address, write data, combinational read data). It selects what starts a conversion: a write to the data register, a software trigger, an external pin, one of four timer pulses or one of two PWM pulses. It extracts a 12-bit code from the written data word using either alignment. A settle counter models the conversion time. When that time elapses, the code is copied into the output latch that drives the converter. The block also raises status flags, a DMA request for the next data word and an interrupt.

The conversion sequencer is a two-state machine. In state CV_IDLE the block waits. The transition IDLE->SETTLE is taken on an accepted start, and it loads the settle counter from the delay register. In state CV_SETTLE the block counts down. The transition SETTLE->SETTLE is taken while the count is above one. The transition SETTLE->IDLE is taken on the last settle cycle, and it updates the output latch and sets the finish flag. A start is accepted only in CV_IDLE.

Top module: `dac_trig_ctl`

## Requirements
- R1: With control bit 3 (trigger enable) clear, a write to word address 1 (data) starts a conversion of the newly written word.
- R2: With trigger enable set and control bits [6:4] (source) equal to 0, a data write alone starts nothing. Writing 1 to bit 0 of word address 3 starts a conversion, and word address 3 always reads back 0.
- R3: With control bit 10 clear, the code is data bits [11:0]. With bit 10 set, the code is data bits [15:4]. All other data bits do not affect the code.
- R4: The busy flag is status bit 8 at word address 2 and is also the `conv_busy` port. It stays high for exactly the number of cycles held in word address 4 (reset value 8; a value of 0 acts as 1). When busy falls, `dac_code` takes the code of the data register as it stands at that moment.
- R5: Status bit 0 (finish) is set when a conversion completes. Writing 1 to it clears it, and a completion in the same cycle wins over the clear.
- R6: Source 1 selects the external pin. It passes through a two-flop synchronizer and is then detected according to control bits [9:8]: 0 low level, 1 high level, 2 falling edge, 3 rising edge. A level held active restarts a conversion each time the block returns to idle.
- R7: Sources 2 to 5 select timer pulses 0 to 3, and sources 6 and 7 select PWM pulses 0 and 1. Pulses on unselected inputs are ignored.
- R8: With control bit 2 (DMA mode) set, an accepted hardware trigger (source 1 to 7) raises `dma_req`. It stays high until `dma_ack`.
- R9: Suppose a hardware trigger arrives in DMA mode while `dma_req` is still high and no `dma_ack` comes in the same cycle. Then status bit 1 (under-run) is set, no conversion starts and `dac_code` keeps its value. Writing 1 to status bit 1 clears it.
- R10: `irq` equals (control bit 0 AND finish) OR (control bit 1 AND under-run).
- R11: Triggers that arrive while a conversion is in progress are ignored.
- R12: After reset, control is 0, delay is 8, status is 0, and `dac_code`, `dma_req`, `irq` and `conv_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address: 0 control, 1 data, 2 status, 3 software trigger, 4 delay |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| tmr_trig | input | 4 | Timer trigger pulses |
| pwm_trig | input | 2 | PWM trigger pulses |
| dma_ack | input | 1 | DMA request serviced |
| dma_req | output | 1 | Request for the next data word |
| irq | output | 1 | Interrupt |
| conv_busy | output | 1 | Conversion in progress |
| dac_code | output | 12 | Output latch to the converter |

## Verification
The bench targets off-by-one settle timing: a counter that is loaded or compared one step off shows up as a busy window one cycle too long or too short. It drives a held level on the pin and counts restarts, which exposes a design that latches a level only once or starts twice per idle gap. It fires a second hardware trigger while a DMA request is still pending. A design that forgot the suppression would emit an unexpected conversion and overwrite the output, and the scoreboard reports that as an unexpected item. Swapped alignment bit fields and pulses that leak through from unselected sources appear as wrong codes or as extra conversions.

// File: rtl/dac_tc_pkg.sv
package dac_tc_pkg;

    localparam int N_TMR    = 4;
    localparam int N_PWM    = 2;
    localparam int N_SRC    = 2 + N_TMR + N_PWM;
    localparam int ADDR_W   = 3;
    localparam int CTRL_W   = 11;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DATA  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_SWTRG = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_DLY   = 3'd4;

    // start source selection when triggering is enabled
    typedef enum logic [2:0] {
        SRC_SW   = 3'd0,
        SRC_PIN  = 3'd1,
        SRC_TMR0 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_TMR2 = 3'd4,
        SRC_TMR3 = 3'd5,
        SRC_PWM0 = 3'd6,
        SRC_PWM1 = 3'd7
    } src_sel_e;

    // detection of the synchronized external pin
    typedef enum logic [1:0] {
        PIN_LOW  = 2'd0,
        PIN_HIGH = 2'd1,
        PIN_FALL = 2'd2,
        PIN_RISE = 2'd3
    } pin_mode_e;

    typedef enum logic {
        CV_IDLE   = 1'b0,
        CV_SETTLE = 1'b1
    } conv_state_e;

    // control word, bit 0 at the bottom
    typedef struct packed {
        logic      left_align;  // [10]
        pin_mode_e pin_mode;    // [9:8]
        logic      rsvd;        // [7]
        src_sel_e  src;         // [6:4]
        logic      trig_en;     // [3]
        logic      dma_en;      // [2]
        logic      udr_ie;      // [1]
        logic      done_ie;     // [0]
    } ctrl_t;

    localparam logic [CTRL_W-1:0] CTRL_WMASK = 11'h77F;

endpackage

// File: rtl/dac_trig_sel.sv
module dac_trig_sel
    import dac_tc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             sw_pulse,
    input  logic             data_wr,
    input  logic             pin_raw,
    input  logic [N_TMR-1:0] tmr,
    input  logic [N_PWM-1:0] pwm,
    output logic             trig_evt,
    output logic             hw_evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_prev_q;
    logic                   pin_s;
    logic                   pin_evt;
    logic [N_SRC-1:0]       src_vec;

    // metastability chain for the asynchronous pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= '0;
            pin_prev_q <= 1'b0;
        end else begin
            sync_q     <= {sync_q[SYNC_STAGES-2:0], pin_raw};
            pin_prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    always_comb begin
        unique case (ctrl.pin_mode)
            PIN_LOW:  pin_evt = !pin_s;
            PIN_HIGH: pin_evt = pin_s;
            PIN_FALL: pin_evt = pin_prev_q && !pin_s;
            PIN_RISE: pin_evt = !pin_prev_q && pin_s;
        endcase
    end

    assign src_vec[0] = sw_pulse;
    assign src_vec[1] = pin_evt;

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        assign src_vec[2+t] = tmr[t];
    end

    for (genvar p = 0; p < N_PWM; p++) begin : g_pwm
        assign src_vec[2+N_TMR+p] = pwm[p];
    end

    always_comb begin
        if (ctrl.trig_en) begin
            trig_evt = src_vec[ctrl.src];
            hw_evt   = src_vec[ctrl.src] && (ctrl.src != SRC_SW);
        end else begin
            trig_evt = data_wr;
            hw_evt   = 1'b0;
        end
    end

endmodule

// File: rtl/dac_dma_track.sv
module dac_dma_track (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_accept,
    input  logic dma_ack,
    input  logic udr_clr,
    output logic dma_req,
    output logic udr_flag,
    output logic block
);

    // a new hardware trigger while the last request is unserviced
    assign block = hw_accept && dma_req && !dma_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_req  <= 1'b0;
            udr_flag <= 1'b0;
        end else begin
            if (hw_accept && !block) begin
                dma_req <= 1'b1;
            end else if (dma_ack) begin
                dma_req <= 1'b0;
            end

            if (block) begin
                udr_flag <= 1'b1;
            end else if (udr_clr) begin
                udr_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dac_conv_fsm.sv
module dac_conv_fsm
    import dac_tc_pkg::*;
#(
    parameter int DLY_W  = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DLY_W-1:0]  delay,
    input  logic [CODE_W-1:0] hold_code,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] code_q
);

    conv_state_e      state_q, state_d;
    logic [DLY_W-1:0] cnt_q;
    logic             last;

    // state register, settle counter and output latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CV_IDLE;
            cnt_q   <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                CV_IDLE: begin
                    if (start) begin
                        cnt_q <= (delay == '0) ? DLY_W'(1) : delay;
                    end
                end
                CV_SETTLE: begin
                    if (last) begin
                        code_q <= hold_code;
                    end else begin
                        cnt_q <= cnt_q - DLY_W'(1);
                    end
                end
            endcase
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        busy    = 1'b0;
        last    = 1'b0;
        unique case (state_q)
            CV_IDLE: begin
                if (start) state_d = CV_SETTLE;
            end
            CV_SETTLE: begin
                busy = 1'b1;
                last = (cnt_q == DLY_W'(1));
                if (last) state_d = CV_IDLE;
            end
        endcase
        done = last;
    end

endmodule

// File: rtl/dac_trig_ctl.sv
module dac_trig_ctl
    import dac_tc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CODE_W      = 12,
    parameter int DLY_W       = 8,
    parameter int DLY_RST     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_pin,
    input  logic [N_TMR-1:0]  tmr_trig,
    input  logic [N_PWM-1:0]  pwm_trig,
    input  logic              dma_ack,
    output logic              dma_req,
    output logic              irq,
    output logic              conv_busy,
    output logic [CODE_W-1:0] dac_code
);

    localparam int LEFT_LSB = 4;
    localparam int BUSY_BIT = 8;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] data_q;
    logic [DLY_W-1:0]  dly_q;
    logic              fin_q;
    logic              udr_q;

    logic              wr_ctrl, wr_data, wr_stat, wr_dly, sw_pulse;
    logic              trig_evt, hw_evt, accept, hw_accept, block, start, done;
    logic [CODE_W-1:0] hold_code;

    assign wr_ctrl  = reg_we && (reg_addr == ADR_CTRL);
    assign wr_data  = reg_we && (reg_addr == ADR_DATA);
    assign wr_stat  = reg_we && (reg_addr == ADR_STAT);
    assign wr_dly   = reg_we && (reg_addr == ADR_DLY);
    assign sw_pulse = reg_we && (reg_addr == ADR_SWTRG) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            data_q <= '0;
            dly_q  <= DLY_W'(DLY_RST);
            fin_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0] & CTRL_WMASK);
            if (wr_data) data_q <= reg_wdata;
            if (wr_dly)  dly_q  <= reg_wdata[DLY_W-1:0];
            if (done) begin
                fin_q <= 1'b1;
            end else if (wr_stat && reg_wdata[0]) begin
                fin_q <= 1'b0;
            end
        end
    end

    assign hold_code = ctrl_q.left_align ? data_q[LEFT_LSB +: CODE_W]
                                         : data_q[CODE_W-1:0];

    dac_trig_sel #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl_q),
        .sw_pulse(sw_pulse),
        .data_wr (wr_data),
        .pin_raw (ext_pin),
        .tmr     (tmr_trig),
        .pwm     (pwm_trig),
        .trig_evt(trig_evt),
        .hw_evt  (hw_evt)
    );

    assign accept    = trig_evt && !conv_busy;
    assign hw_accept = accept && hw_evt && ctrl_q.dma_en;
    assign start     = accept && !block;

    dac_dma_track u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_accept(hw_accept),
        .dma_ack  (dma_ack),
        .udr_clr  (wr_stat && reg_wdata[1]),
        .dma_req  (dma_req),
        .udr_flag (udr_q),
        .block    (block)
    );

    dac_conv_fsm #(
        .DLY_W (DLY_W),
        .CODE_W(CODE_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .delay    (dly_q),
        .hold_code(hold_code),
        .busy     (conv_busy),
        .done     (done),
        .code_q   (dac_code)
    );

    assign irq = (ctrl_q.done_ie && fin_q) || (ctrl_q.udr_ie && udr_q);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CTRL: reg_rdata = DATA_W'(ctrl_q);
            ADR_DATA: reg_rdata = data_q;
            ADR_STAT: begin
                reg_rdata[0]        = fin_q;
                reg_rdata[1]        = udr_q;
                reg_rdata[BUSY_BIT] = conv_busy;
            end
            ADR_DLY:  reg_rdata = DATA_W'(dly_q);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dac_trig_ctl_chk.sv
module dac_trig_ctl_chk
    import dac_tc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              dma_req,
    input logic              dma_ack,
    input logic              conv_busy,
    input logic [CODE_W-1:0] dac_code,
    input logic              fin,
    input logic              udr
);

    assert_swtrg_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_SWTRG) |-> (reg_rdata == '0));

    assert_code_moves_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> $fell(conv_busy));

    assert_finish_on_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_busy) |-> fin);

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req);

    assert_udr_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udr) |-> $past(dma_req));

    assert_udr_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udr) |-> !conv_busy);

endmodule

bind dac_trig_ctl dac_trig_ctl_chk #(
    .DATA_W(DATA_W),
    .CODE_W(CODE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .dma_req  (dma_req),
    .dma_ack  (dma_ack),
    .conv_busy(conv_busy),
    .dac_code (dac_code),
    .fin      (fin_q),
    .udr      (udr_q)
);

// File: tb/tb_dac_trig_ctl.sv
module tb_dac_trig_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_pin = 1'b0;
    logic [3:0]  tmr_trig = '0;
    logic [1:0]  pwm_trig = '0;
    logic        dma_ack = 1'b0;
    logic        dma_req, irq, conv_busy;
    logic [11:0] dac_code;

    always #4 clk = ~clk;

    dac_trig_ctl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
        .tmr_trig(tmr_trig), .pwm_trig(pwm_trig), .dma_ack(dma_ack),
        .dma_req(dma_req), .irq(irq), .conv_busy(conv_busy), .dac_code(dac_code)
    );

    typedef struct {
        logic [11:0] code;
        int          len;
        string       req;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    errors = 0;
    int    run_len = 0;
    string cur_req = "R12";
    bit    finished = 1'b0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(logic [11:0] code, int len, string req);
        exp_t e;
        e.code = code; e.len = len; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse_src(int idx);
        if (idx < 4) tmr_trig[idx] = 1'b1;
        else         pwm_trig[idx-4] = 1'b1;
        @(negedge clk);
        tmr_trig = '0;
        pwm_trig = '0;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (conv_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_starts(int n);
        int  seen = 0;
        logic p = conv_busy;
        while (seen < n) begin
            @(negedge clk);
            if (conv_busy && !p) seen++;
            p = conv_busy;
        end
    endtask

    // monitor: every finished conversion is compared with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (conv_busy) begin
                run_len++;
            end else if (run_len > 0) begin
                if (sb_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL %s unexpected conversion: actual code %0h expected none",
                             cur_req, dac_code);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(e.req, 32'(dac_code), 32'(e.code), "output code");
                    chk(e.req, 32'(run_len), 32'(e.len), "busy cycles");
                end
                run_len = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12", 32'(dac_code), 0, "code");
        chk("R12", {29'b0, conv_busy, dma_req, irq}, 0, "busy/req/irq");
        rd(0, v); chk("R12", v, 0, "control");
        rd(4, v); chk("R12", v, 8, "delay");
        rd(2, v); chk("R12", v, 0, "status");

        // R1 data write trigger, R3 right alignment, R4 busy window
        cur_req = "R1";
        wr(4, 4);
        wr(0, 32'h0);
        push(12'hABC, 4, "R1");
        wr(1, 32'hFFFF_FABC);
        rd(2, v); chk("R4", v & 32'h100, 32'h100, "status busy bit");
        wait_idle();
        rd(2, v); chk("R5", v & 32'h1, 1, "finish after completion");
        chk("R10", 32'(irq), 0, "irq with enables off");

        // R3 left alignment
        cur_req = "R3";
        wr(0, 32'h400);
        push(12'hA3C, 4, "R3");
        wr(1, 32'h1235_A3C7);
        wait_idle();

        // R5 finish write-1-to-clear
        wr(2, 32'h1);
        rd(2, v); chk("R5", v, 0, "status after clear");

        // R10 done interrupt
        cur_req = "R10";
        wr(0, 32'h401);
        chk("R10", 32'(irq), 0, "irq before completion");
        push(12'h001, 4, "R10");
        wr(1, 32'h0000_0010);
        wait_idle();
        chk("R10", 32'(irq), 1, "irq on finish");
        wr(2, 32'h1);
        chk("R10", 32'(irq), 0, "irq after clear");

        // R2 software trigger
        cur_req = "R2";
        wr(0, 32'h008);
        wr(1, 32'h0000_0123);
        repeat (10) @(negedge clk);
        chk("R2", 32'(conv_busy), 0, "data write must not start");
        chk("R2", 32'(dac_code), 32'h001, "code kept");
        rd(3, v); chk("R2", v, 0, "trigger register reads 0");
        push(12'h123, 4, "R2");
        wr(3, 32'h1);
        rd(3, v); chk("R2", v, 0, "trigger register reads 0 after write");
        wait_idle();

        // R11 trigger while busy is ignored
        cur_req = "R11";
        push(12'h123, 4, "R11");
        wr(3, 32'h1);
        wr(3, 32'h1);
        wait_idle();
        repeat (8) @(negedge clk);
        chk("R11", 32'(sb_q.size()), 0, "pending items");

        // R4 delay register and latch timing
        cur_req = "R4";
        wr(4, 1);
        wr(1, 32'h0000_0456);
        push(12'h456, 1, "R4");
        wr(3, 32'h1);
        wait_idle();
        wr(4, 6);
        wr(1, 32'h0000_0789);
        push(12'h789, 6, "R4");
        wr(3, 32'h1);
        wait_idle();
        wr(4, 3);

        // R7 timer and PWM sources, unselected pulses ignored
        cur_req = "R7";
        for (int s = 2; s < 8; s++) begin
            wr(0, 32'h008 | (s << 4));
            wr(1, 32'h100 + s);
            pulse_src((s - 1) % 6);
            repeat (6) @(negedge clk);
            chk("R7", 32'(conv_busy), 0, "unselected pulse");
            push(12'h100 + 12'(s), 3, "R7");
            pulse_src(s - 2);
            wait_idle();
        end

        // R6 external pin modes
        cur_req = "R6";
        wr(1, 32'h777);
        wr(0, 32'h318);
        push(12'h777, 3, "R6");
        ext_pin = 1'b1;
        wait_idle();
        wr(0, 32'h218);
        wr(1, 32'h666);
        push(12'h666, 3, "R6");
        ext_pin = 1'b0;
        wait_idle();
        wr(0, 32'h118);
        wr(1, 32'h555);
        repeat (6) @(negedge clk);
        chk("R6", 32'(conv_busy), 0, "high level mode with pin low");
        push(12'h555, 3, "R6");
        push(12'h555, 3, "R6");
        ext_pin = 1'b1;
        wait_starts(2);
        ext_pin = 1'b0;
        wait_idle();
        push(12'h555, 3, "R6");
        push(12'h555, 3, "R6");
        wr(0, 32'h018);
        wait_starts(2);
        ext_pin = 1'b1;
        wait_idle();
        repeat (6) @(negedge clk);
        chk("R6", 32'(sb_q.size()), 0, "level restart count");

        // R8 DMA request, R9 under-run
        cur_req = "R8";
        wr(4, 2);
        wr(1, 32'h9AB);
        wr(0, 32'h02E);
        push(12'h9AB, 2, "R8");
        pulse_src(0);
        chk("R8", 32'(dma_req), 1, "request after hardware trigger");
        wait_idle();
        chk("R8", 32'(dma_req), 1, "request held");
        cur_req = "R9";
        wr(1, 32'h111);
        pulse_src(0);
        repeat (6) @(negedge clk);
        rd(2, v); chk("R9", v & 32'h2, 32'h2, "under-run flag");
        chk("R9", 32'(dac_code), 32'h9AB, "code kept");
        chk("R10", 32'(irq), 1, "irq on under-run");
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        chk("R8", 32'(dma_req), 0, "request cleared by ack");
        wr(2, 32'h2);
        rd(2, v); chk("R9", v & 32'h2, 0, "under-run cleared");
        chk("R10", 32'(irq), 0, "irq after under-run clear");
        cur_req = "R8";
        push(12'h111, 2, "R8");
        pulse_src(0);
        wait_idle();
        chk("R8", 32'(dma_req), 1, "request after serviced trigger");

        repeat (5) @(negedge clk);
        chk("R1", 32'(sb_q.size()), 0, "all expected conversions seen");
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule